// File: doc/BRIEF.md
# Pulse-and-Verify One-Time-Programmable Memory Writer

This block is the programmer-side controller that burns an image into a one-time-programmable word memory. After a start request it reads every location at the nominal supply to confirm the part is blank (all ones). It then walks the user locations, taking each word from an image buffer over a valid/ready stream. For every word it applies a program pulse, counts it, and reads the word back. Once the readback first matches, it adds a margin of A·N+B extra pulses, where N is the number of pulses the word needed. Then it moves to the next address.

When the whole array is written, the block re-reads it twice against the image: once with the minimum-supply flag raised and once with the maximum-supply flag raised. The configuration word, taken from a port, is written last with the same pulse/verify/margin loop. It is then verified at both supply levels. The pulse width is given in clock cycles. The limits and the margin coefficients are captured into internal registers when start is accepted. Their reset values are: at most 8 pulses, A=11, B=0.

The image stream works as follows. The block raises `img_ready` together with the address it wants. It keeps both steady until the buffer answers with `img_valid`, and it takes `img_data` in the cycle where both are high. The buffer may hold `img_valid` low for any number of cycles, and the block simply waits. The memory port returns read data in the cycle after a one-cycle `mem_rd` strobe.

Top module: `otp_pulse_prog`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `mem_pgm`, `mem_rd`, `img_ready`, `supply_min` and `supply_max` are all 0.
- R2: The blank check reads every location 0..`last_addr` with neither supply flag raised, and expects all ones. On a mismatch with `cont_blank`=0, the block stops with `done`=1 and `err`=1, having issued no program pulse.
- R3: With `cont_blank`=1, a blank mismatch sets `err`=1 but the full write/verify sequence still runs. The code stays 1 unless a later failure replaces it.
- R4: Each program pulse holds `mem_pgm` high for `pulse_len` cycles, or 1 cycle when `pulse_len` is 0. `mem_wdata` and `mem_addr` are steady across the pulse. Each pulse is followed by a verify read.
- R5: If a word still mismatches after `max_pulses` pulses, the block stops with `err`=2. A word that first matches on exactly the `max_pulses`-th pulse is accepted.
- R6: After the first match at pulse count N, exactly `over_a`·N+`over_b` further pulses are applied to the word. Each is separated by at least one low cycle of `mem_pgm`.
- R7: `img_ready` and `img_addr` stay steady until `img_valid` is seen; a stalled buffer only delays the sequence.
- R8: The minimum-supply verify pass raises `supply_min`. A mismatch there ends the run with `err`=3.
- R9: The maximum-supply verify pass raises `supply_max`. A mismatch there ends the run with `err`=4.
- R10: The configuration word is written after both array verify passes, with `mem_cfg_sel`=1. It uses the same pulse/margin loop; a program failure gives `err`=5. It is then verified at minimum and maximum supply; a mismatch gives `err`=6.
- R11: `busy` is high from the accepted start until the run ends. `done` and `err` then hold until the next start, and `busy` and `done` are never high together.
- R12: `mem_pgm` and `mem_rd` are never high together, and `supply_min` and `supply_max` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a run when idle or done; captures the settings below |
| cont_blank | input | 1 | Keep going after a blank-check mismatch |
| pulse_len | input | 16 | Program pulse width in cycles (0 acts as 1) |
| max_pulses | input | 4 | Pulse limit per word |
| over_a | input | 8 | Margin multiplier A |
| over_b | input | 8 | Margin offset B |
| last_addr | input | AW | Highest user address to write |
| cfg_word | input | DW | Configuration word value |
| img_ready | output | 1 | Block is ready to take the image word at `img_addr` |
| img_addr | output | AW | Address of the wanted image word |
| img_valid | input | 1 | Image buffer presents `img_data` |
| img_data | input | DW | Image word |
| mem_addr | output | AW | Memory address for pulse or read |
| mem_cfg_sel | output | 1 | Access targets the configuration word |
| mem_wdata | output | DW | Data to program |
| mem_pgm | output | 1 | Program pulse active |
| mem_rd | output | 1 | Read strobe; data expected next cycle |
| mem_rdata | input | DW | Read data |
| supply_min | output | 1 | Minimum-supply verify pass in progress |
| supply_max | output | 1 | Maximum-supply verify pass in progress |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (held) |
| err | output | 3 | Result code: 0 ok, 1 blank, 2 program, 3 min verify, 4 max verify, 5 config program, 6 config verify |

## Verification
The checker watches every cycle for the interface rules that hold in any run. These are: pulse and read never overlap, the two supply flags are exclusive, data and address are steady under a pulse, the image request is held under back-pressure, and `done` and `err` are held once a run ends. The pulse counts, the A·N+B margin, the abort at the pulse limit, the ordering of passes and which error code each failure yields depend on the memory's response. Only the bench scenarios can show these. Its memory model needs a chosen number of pulses per word and can corrupt reads at one supply level.

// File: rtl/otp_pp_pkg.sv
package otp_pp_pkg;
  typedef enum logic [2:0] {
    PH_BLANK, PH_PROG, PH_VMIN, PH_VMAX, PH_CPROG, PH_CVMIN, PH_CVMAX
  } phase_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_PULSE, ST_VRD, ST_VCMP, ST_OVER, ST_OGAP, ST_DONE
  } state_t;

  localparam logic [2:0] ERR_NONE  = 3'd0;
  localparam logic [2:0] ERR_BLANK = 3'd1;
  localparam logic [2:0] ERR_PROG  = 3'd2;
  localparam logic [2:0] ERR_VMIN  = 3'd3;
  localparam logic [2:0] ERR_VMAX  = 3'd4;
  localparam logic [2:0] ERR_CPROG = 3'd5;
  localparam logic [2:0] ERR_CVFY  = 3'd6;

  localparam int DEF_OVER_A = 11;
  localparam int DEF_OVER_B = 0;
  localparam int DEF_MAXP   = 8;
endpackage

// File: rtl/otp_pp_timer.sv
module otp_pp_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] len,
  output logic         last
);
  logic [W-1:0] cnt;
  logic [W-1:0] lim;

  assign lim  = (len == '0) ? '0 : len - 1'b1;
  assign last = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run || last) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/otp_pp_tries.sv
module otp_pp_tries #(
  parameter int NW = 4,
  parameter int CW = 8,
  parameter int XW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic          load,
  input  logic          dec,
  input  logic [CW-1:0] coef_a,
  input  logic [CW-1:0] coef_b,
  output logic [NW-1:0] n,
  output logic          extra_zero,
  output logic          rem_zero
);
  logic [XW-1:0] extra;
  logic [XW-1:0] rem;

  assign extra      = XW'(coef_a) * XW'(n) + XW'(coef_b);
  assign extra_zero = (extra == '0);
  assign rem_zero   = (rem == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n   <= '0;
      rem <= '0;
    end else begin
      if (clr)      n <= '0;
      else if (inc) n <= n + 1'b1;
      if (load)     rem <= extra;
      else if (dec) rem <= rem - 1'b1;
    end
  end
endmodule

// File: rtl/otp_pulse_prog.sv
module otp_pulse_prog
  import otp_pp_pkg::*;
#(
  parameter int AW  = 3,
  parameter int DW  = 12,
  parameter int PLW = 16,
  parameter int NW  = 4,
  parameter int CW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cont_blank,
  input  logic [PLW-1:0] pulse_len,
  input  logic [NW-1:0] max_pulses,
  input  logic [CW-1:0] over_a,
  input  logic [CW-1:0] over_b,
  input  logic [AW-1:0] last_addr,
  input  logic [DW-1:0] cfg_word,
  output logic          img_ready,
  output logic [AW-1:0] img_addr,
  input  logic          img_valid,
  input  logic [DW-1:0] img_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cfg_sel,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_pgm,
  output logic          mem_rd,
  input  logic [DW-1:0] mem_rdata,
  output logic          supply_min,
  output logic          supply_max,
  output logic          busy,
  output logic          done,
  output logic [2:0]    err
);
  localparam int XW = 2 * CW + NW;

  state_t state, nxt_state;
  phase_t phase, nxt_phase;
  logic [AW-1:0] addr, nxt_addr;
  logic [2:0]    nxt_err;
  logic [DW-1:0] word;
  logic          take;

  logic           r_cont;
  logic [PLW-1:0] r_plen;
  logic [NW-1:0]  r_max;
  logic [CW-1:0]  r_a, r_b;
  logic [AW-1:0]  r_last;
  logic [DW-1:0]  r_cfgw;

  logic t_run, t_last, t_clr, t_inc, t_load, t_dec, ld_cfg, adv, fin;
  logic [NW-1:0] n;
  logic extra_zero, rem_zero, match, at_last;
  logic [2:0] fin_code;

  assign take    = start && (state == ST_IDLE || state == ST_DONE);
  assign at_last = (addr == r_last);
  assign match   = (mem_rdata == ((phase == PH_BLANK) ? {DW{1'b1}} : word));
  assign t_run   = (state == ST_PULSE) || (state == ST_OVER);
  assign t_inc   = (state == ST_PULSE) && t_last;
  assign t_dec   = (state == ST_OVER) && t_last;

  otp_pp_timer #(.W(PLW)) i_timer (
    .clk(clk), .rst_n(rst_n), .run(t_run), .len(r_plen), .last(t_last)
  );

  otp_pp_tries #(.NW(NW), .CW(CW), .XW(XW)) i_tries (
    .clk(clk), .rst_n(rst_n), .clr(t_clr), .inc(t_inc), .load(t_load),
    .dec(t_dec), .coef_a(r_a), .coef_b(r_b), .n(n),
    .extra_zero(extra_zero), .rem_zero(rem_zero)
  );

  always_comb begin
    nxt_state = state;
    nxt_phase = phase;
    nxt_addr  = addr;
    nxt_err   = err;
    t_clr = 1'b0; t_load = 1'b0; ld_cfg = 1'b0;
    adv = 1'b0; fin = 1'b0; fin_code = ERR_NONE;
    unique case (state)
      ST_FETCH: begin
        t_clr = 1'b1;
        if (img_valid) nxt_state = (phase == PH_PROG) ? ST_PULSE : ST_VRD;
      end
      ST_PULSE: if (t_last) nxt_state = ST_VRD;
      ST_VRD:   nxt_state = ST_VCMP;
      ST_VCMP: begin
        unique case (phase)
          PH_BLANK: begin
            if (!match && !r_cont) begin fin = 1'b1; fin_code = ERR_BLANK; end
            else begin
              adv = 1'b1;
              if (!match) nxt_err = ERR_BLANK;
            end
          end
          PH_PROG, PH_CPROG: begin
            if (match) begin
              if (extra_zero) adv = 1'b1;
              else begin t_load = 1'b1; nxt_state = ST_OVER; end
            end else if (n >= r_max) begin
              fin = 1'b1;
              fin_code = (phase == PH_PROG) ? ERR_PROG : ERR_CPROG;
            end else nxt_state = ST_PULSE;
          end
          PH_VMIN: if (match) adv = 1'b1; else begin fin = 1'b1; fin_code = ERR_VMIN; end
          PH_VMAX: if (match) adv = 1'b1; else begin fin = 1'b1; fin_code = ERR_VMAX; end
          default: if (match) adv = 1'b1; else begin fin = 1'b1; fin_code = ERR_CVFY; end
        endcase
      end
      ST_OVER: if (t_last) nxt_state = ST_OGAP;
      ST_OGAP: if (rem_zero) adv = 1'b1; else nxt_state = ST_OVER;
      default: ;
    endcase

    if (adv) begin
      unique case (phase)
        PH_BLANK: begin
          nxt_addr  = at_last ? '0 : addr + 1'b1;
          nxt_phase = at_last ? PH_PROG : PH_BLANK;
          nxt_state = at_last ? ST_FETCH : ST_VRD;
        end
        PH_PROG: begin
          nxt_addr  = at_last ? '0 : addr + 1'b1;
          nxt_phase = at_last ? PH_VMIN : PH_PROG;
          nxt_state = ST_FETCH;
        end
        PH_VMIN: begin
          nxt_addr  = at_last ? '0 : addr + 1'b1;
          nxt_phase = at_last ? PH_VMAX : PH_VMIN;
          nxt_state = ST_FETCH;
        end
        PH_VMAX: begin
          if (at_last) begin
            nxt_phase = PH_CPROG; nxt_state = ST_PULSE;
            t_clr = 1'b1; ld_cfg = 1'b1;
          end else begin
            nxt_addr = addr + 1'b1; nxt_state = ST_FETCH;
          end
        end
        PH_CPROG: begin nxt_phase = PH_CVMIN; nxt_state = ST_VRD; end
        PH_CVMIN: begin nxt_phase = PH_CVMAX; nxt_state = ST_VRD; end
        default:  nxt_state = ST_DONE;
      endcase
    end
    if (fin) begin
      nxt_state = ST_DONE;
      nxt_err   = fin_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      phase  <= PH_BLANK;
      addr   <= '0;
      err    <= ERR_NONE;
      word   <= '0;
      r_cont <= 1'b0;
      r_plen <= PLW'(1);
      r_max  <= NW'(DEF_MAXP);
      r_a    <= CW'(DEF_OVER_A);
      r_b    <= CW'(DEF_OVER_B);
      r_last <= '0;
      r_cfgw <= '1;
    end else if (take) begin
      state  <= ST_VRD;
      phase  <= PH_BLANK;
      addr   <= '0;
      err    <= ERR_NONE;
      r_cont <= cont_blank;
      r_plen <= pulse_len;
      r_max  <= max_pulses;
      r_a    <= over_a;
      r_b    <= over_b;
      r_last <= last_addr;
      r_cfgw <= cfg_word;
    end else begin
      state <= nxt_state;
      phase <= nxt_phase;
      addr  <= nxt_addr;
      err   <= nxt_err;
      if (state == ST_FETCH && img_valid) word <= img_data;
      else if (ld_cfg)                    word <= r_cfgw;
    end
  end

  assign busy        = (state != ST_IDLE) && (state != ST_DONE);
  assign done        = (state == ST_DONE);
  assign img_ready   = (state == ST_FETCH);
  assign img_addr    = addr;
  assign mem_addr    = addr;
  assign mem_wdata   = word;
  assign mem_pgm     = t_run;
  assign mem_rd      = (state == ST_VRD);
  assign mem_cfg_sel = busy && (phase == PH_CPROG || phase == PH_CVMIN || phase == PH_CVMAX);
  assign supply_min  = busy && (phase == PH_VMIN || phase == PH_CVMIN);
  assign supply_max  = busy && (phase == PH_VMAX || phase == PH_CVMAX);
endmodule

// File: rtl/otp_pp_chk.sv
module otp_pp_chk #(
  parameter int AW = 3,
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          img_ready,
  input logic          img_valid,
  input logic [AW-1:0] img_addr,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_pgm,
  input logic          mem_rd,
  input logic          supply_min,
  input logic          supply_max,
  input logic          busy,
  input logic          done,
  input logic [2:0]    err
);
  // R12
  pgm_rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_pgm && mem_rd));
  // R12
  supply_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(supply_min && supply_max));
  // R7
  img_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    img_ready && !img_valid |=> img_ready && $stable(img_addr));
  // R4
  pulse_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_pgm && $past(mem_pgm) |-> $stable(mem_wdata) && $stable(mem_addr));
  // R4
  pulse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_pgm |-> busy);
  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(err));
  // R11
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

bind otp_pulse_prog otp_pp_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .img_ready(img_ready),
  .img_valid(img_valid), .img_addr(img_addr), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_pgm(mem_pgm), .mem_rd(mem_rd),
  .supply_min(supply_min), .supply_max(supply_max), .busy(busy),
  .done(done), .err(err)
);

// File: tb/test_otp_pulse_prog.sv
`timescale 1ns/1ps
module test_otp_pulse_prog;
  localparam int AW = 3;
  localparam int DW = 12;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] LAST = 3'd3;
  localparam logic [DW-1:0] CFGW = 12'hFF3;

  typedef struct packed {
    logic        cont;
    logic [3:0]  maxp;
    logic [7:0]  a;
    logic [7:0]  b;
    logic [7:0]  need;
    logic [7:0]  cneed;
    logic [3:0]  bbad;
    logic [3:0]  fmin;
    logic [3:0]  fmax;
    logic [3:0]  stall;
    logic [15:0] plen;
    logic [2:0]  xerr;
    logic [15:0] xp0;
    logic [15:0] xpc;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd8, 8'd11, 8'd0, 8'd1, 8'd1, 4'd15, 4'd15, 4'd15, 4'd0, 16'd3, 3'd0, 16'd12, 16'd12},
    '{1'b0, 4'd8, 8'd2,  8'd1, 8'd3, 8'd3, 4'd15, 4'd15, 4'd15, 4'd3, 16'd2, 3'd0, 16'd10, 16'd10},
    '{1'b0, 4'd8, 8'd11, 8'd0, 8'd9, 8'd1, 4'd15, 4'd15, 4'd15, 4'd0, 16'd2, 3'd2, 16'd8,  16'd0},
    '{1'b0, 4'd8, 8'd11, 8'd0, 8'd1, 8'd1, 4'd2,  4'd15, 4'd15, 4'd0, 16'd2, 3'd1, 16'd0,  16'd0},
    '{1'b1, 4'd8, 8'd0,  8'd0, 8'd1, 8'd1, 4'd2,  4'd15, 4'd15, 4'd0, 16'd2, 3'd1, 16'd1,  16'd1},
    '{1'b0, 4'd8, 8'd11, 8'd0, 8'd1, 8'd1, 4'd15, 4'd1,  4'd15, 4'd0, 16'd1, 3'd3, 16'd12, 16'd0},
    '{1'b0, 4'd8, 8'd11, 8'd0, 8'd1, 8'd1, 4'd15, 4'd15, 4'd3,  4'd0, 16'd1, 3'd4, 16'd12, 16'd0},
    '{1'b0, 4'd4, 8'd11, 8'd0, 8'd1, 8'd5, 4'd15, 4'd15, 4'd15, 4'd0, 16'd1, 3'd5, 16'd12, 16'd4},
    '{1'b0, 4'd8, 8'd11, 8'd0, 8'd1, 8'd2, 4'd15, 4'd8,  4'd15, 4'd0, 16'd0, 3'd6, 16'd12, 16'd24},
    '{1'b0, 4'd2, 8'd0,  8'd0, 8'd2, 8'd2, 4'd15, 4'd15, 4'd15, 4'd1, 16'd4, 3'd0, 16'd2,  16'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          start = 1'b0, cont_blank = 1'b0;
  logic [15:0]   pulse_len = 16'd1;
  logic [3:0]    max_pulses = 4'd8;
  logic [7:0]    over_a = 8'd11, over_b = 8'd0;
  logic          img_ready, img_valid;
  logic [AW-1:0] img_addr, mem_addr;
  logic [DW-1:0] img_data, mem_wdata, mem_rdata;
  logic          mem_cfg_sel, mem_pgm, mem_rd, supply_min, supply_max, busy, done;
  logic [2:0]    err;

  otp_pulse_prog #(.AW(AW), .DW(DW)) i_otp_pulse_prog (
    .clk(clk), .rst_n(rst_n), .start(start), .cont_blank(cont_blank),
    .pulse_len(pulse_len), .max_pulses(max_pulses), .over_a(over_a),
    .over_b(over_b), .last_addr(LAST), .cfg_word(CFGW),
    .img_ready(img_ready), .img_addr(img_addr), .img_valid(img_valid),
    .img_data(img_data), .mem_addr(mem_addr), .mem_cfg_sel(mem_cfg_sel),
    .mem_wdata(mem_wdata), .mem_pgm(mem_pgm), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .supply_min(supply_min), .supply_max(supply_max),
    .busy(busy), .done(done), .err(err)
  );

  function automatic logic [DW-1:0] img_val(int i);
    return 12'h5A3 ^ DW'(i * 149);
  endfunction

  // image buffer with configurable stall
  int stall = 0;
  int wcnt = 0;
  assign img_data = img_val(int'(img_addr));
  always @(posedge clk) begin
    if (!rst_n) begin
      img_valid <= 1'b0; wcnt <= 0;
    end else if (img_ready && !img_valid) begin
      if (wcnt >= stall) img_valid <= 1'b1;
      else wcnt <= wcnt + 1;
    end else begin
      img_valid <= 1'b0; wcnt <= 0;
    end
  end

  // memory model: a word programs once its pulse count reaches need
  logic [DW-1:0] mem [DEPTH];
  int            pcnt [DEPTH];
  logic [DW-1:0] cmem;
  int ccnt, need, cneed, bbad, fmin, fmax;
  int hi_run, last_w, overlap, saw_min, saw_max;
  logic mdl_clr = 1'b0;
  logic pgm_q;
  always @(posedge clk) begin
    if (mdl_clr) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i]  <= (i == bbad) ? img_val(i) : {DW{1'b1}};
        pcnt[i] <= 0;
      end
      cmem <= {DW{1'b1}}; ccnt <= 0; pgm_q <= 1'b0;
      hi_run <= 0; last_w <= 0; overlap <= 0; saw_min <= 0; saw_max <= 0;
      mem_rdata <= '0;
    end else begin
      pgm_q <= mem_pgm;
      if (mem_pgm) hi_run <= hi_run + 1;
      else if (hi_run != 0) begin last_w <= hi_run; hi_run <= 0; end
      if (mem_pgm && mem_rd) overlap <= overlap + 1;
      if (supply_min) saw_min <= saw_min + 1;
      if (supply_max) saw_max <= saw_max + 1;
      if (mem_pgm && !pgm_q) begin
        if (mem_cfg_sel) begin
          ccnt <= ccnt + 1;
          if (ccnt + 1 >= cneed) cmem <= cmem & mem_wdata;
        end else begin
          pcnt[mem_addr] <= pcnt[mem_addr] + 1;
          if (pcnt[mem_addr] + 1 >= need) mem[mem_addr] <= mem[mem_addr] & mem_wdata;
        end
      end
      if (mem_rd) begin
        mem_rdata <= (mem_cfg_sel ? cmem : mem[mem_addr])
          ^ (((supply_min && (mem_cfg_sel ? fmin == 8 : fmin == int'(mem_addr))) ||
              (supply_max && (mem_cfg_sel ? fmax == 8 : fmax == int'(mem_addr))))
             ? 12'h001 : 12'h000);
      end
    end
  end

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic string tag_of(int k);
    case (k)
      0: return "R6 default margin 11*N";
      1: return "R6 R7 margin A*N+B with stalled image";
      2: return "R5 pulse limit abort";
      3: return "R2 blank mismatch stop";
      4: return "R3 blank mismatch continue";
      5: return "R8 min-supply verify";
      6: return "R9 max-supply verify";
      7: return "R10 config program failure";
      8: return "R10 config verify failure";
      default: return "R5 success on last allowed pulse";
    endcase
  endfunction

  task automatic run_case(input vec_t v, output bit ok);
    int n = 0;
    cont_blank = v.cont; max_pulses = v.maxp; over_a = v.a; over_b = v.b;
    pulse_len = v.plen; need = v.need; cneed = v.cneed; bbad = v.bbad;
    fmin = v.fmin; fmax = v.fmax; stall = v.stall;
    mdl_clr = 1'b1;
    @(negedge clk); mdl_clr = 1'b0;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    ok = done;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && err == 3'd0, "R1 status after reset", {busy, done, err}, 0);
    chk(!mem_pgm && !mem_rd && !img_ready, "R1 strobes after reset", {mem_pgm, mem_rd, img_ready}, 0);
    chk(!supply_min && !supply_max, "R1 supply flags after reset", {supply_min, supply_max}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      run_case(VECS[k], ok);
      chk(ok, {tag_of(k), " R11 done"}, ok, 1);
      chk(err == VECS[k].xerr, {tag_of(k), " err"}, err, VECS[k].xerr);
      chk(pcnt[0] == int'(VECS[k].xp0), {tag_of(k), " pulses at word 0"}, pcnt[0], VECS[k].xp0);
      chk(ccnt == int'(VECS[k].xpc), {tag_of(k), " R10 config pulses"}, ccnt, VECS[k].xpc);
      chk(overlap == 0, "R12 pulse/read overlap", overlap, 0);
      if (VECS[k].xp0 != 0)
        chk(last_w == ((VECS[k].plen == 0) ? 1 : int'(VECS[k].plen)),
            "R4 pulse width", last_w, (VECS[k].plen == 0) ? 1 : int'(VECS[k].plen));
      if (VECS[k].xerr == 3'd0 || VECS[k].xerr == 3'd6 || (VECS[k].xerr == 3'd1 && VECS[k].cont)) begin
        chk(mem[LAST] == img_val(int'(LAST)), {tag_of(k), " R4 last word content"}, mem[LAST], img_val(int'(LAST)));
        chk(cmem == CFGW, {tag_of(k), " R10 config content"}, cmem, CFGW);
      end
      if (VECS[k].xerr == 3'd0)
        chk(saw_min > 0 && saw_max > 0, "R8 R9 both supply passes seen", {saw_min != 0, saw_max != 0}, 3);
      if (VECS[k].xerr == 3'd1 && !VECS[k].cont)
        chk(saw_min == 0 && saw_max == 0 && !supply_min, "R2 blank pass without supply flags", saw_min + saw_max, 0);
    end

    // R11 done and err held while no start arrives
    repeat (30) @(negedge clk);
    chk(done && !busy && err == 3'd0, "R11 result held", {done, busy, err}, 3'b100 << 2);
    // R11 busy soon after a new start, done dropped
    cont_blank = 1'b0; pulse_len = 16'd2; max_pulses = 4'd8; over_a = 8'd11; over_b = 8'd0;
    need = 1; cneed = 1; bbad = 15; fmin = 15; fmax = 15; stall = 0;
    mdl_clr = 1'b1; @(negedge clk); mdl_clr = 1'b0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk(busy && !done, "R11 busy after start", {busy, done}, 2);
    while (!done) @(negedge clk);
    chk(err == 3'd0 && pcnt[2] == 12, "R6 second run margin at word 2", pcnt[2], 12);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule